// File: doc/BRIEF.md
# SMBus Host Controller Register Bank

This block is the byte-wide register bank that software sees in front of an SMBus host controller. Software loads the target address, the command byte, up to 32 payload bytes and a byte count, then writes the protocol byte. That last write is the trigger: the bank hands a one-cycle start pulse to a downstream transaction sequencer and reports busy until the sequencer answers.

While a transaction runs, the status byte reads as zero, so software can poll until it becomes non-zero. On completion the sequencer's result is latched as a done flag, an alarm flag and a five-bit error code. A transaction succeeded only if the done flag is set and the code is zero. Software can also request an abort through the control byte. The sequencer acknowledges the abort, and the bank raises a completion flag that software clears by writing one to it.

The sequencer writes received bytes and the received count straight into the same buffer that software reads. The register bank leaves out all bit-level bus signalling.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every offset 0x00..0x3F reads 0x00, and `seq_start` and `seq_abort` are low.
- R2: While idle, host writes to slave address (0x02), command (0x03), buffer bytes (0x04..0x23, byte k at 0x04+k) and count (0x24) read back unchanged and appear on `seq_slave`, `seq_cmd`, `seq_buf_rdata` (indexed by `seq_buf_ridx`) and `seq_count`. Every other unmapped offset reads 0x00.
- R3: A host write to offset 0x00 while idle stores the protocol byte, which reads back there and drives `seq_proto`. `seq_start` is high for exactly the one cycle after the write edge. From then until completion, offset 0x01 reads 0x00.
- R4: A `seq_done` pulse while busy ends the transaction. Offset 0x01 then reads {done=1 in bit 7, `seq_alarm` in bit 6, 0 in bit 5, code in bits 4:0}, and the code is `seq_err` when that is non-zero.
- R5: A write to 0x00 while busy, including one in the same cycle as `seq_done`, is ignored: no pulse and no change to the protocol byte. The completing code then reads 0x1F, unless `seq_err` is non-zero, in which case `seq_err` is reported.
- R6: Host writes to 0x02..0x24 while busy have no effect.
- R7: While idle, writing ones to 0x01 clears those status bits. An accepted start clears the whole status byte.
- R8: Sequencer writes to the buffer and the count overwrite the host-visible bytes. When the host and the sequencer write the same byte in the same cycle, the sequencer's value is kept.
- R9: Writing the control byte (0x3E) stores every bit except bit 5, which always reads 0. A write with bit 5 set while busy makes `seq_abort` high for exactly the next cycle. While idle, the same write produces no pulse.
- R10: A `seq_abort_ack` pulse while busy ends the transaction. Status then reads 0x1E and bit 0 of 0x3C reads 1. Writing 1 to that bit clears it and writing 0 does not. When an acknowledge and a clearing write fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 6 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr` (combinational) |
| seq_start | output | 1 | One-cycle transaction start pulse |
| seq_abort | output | 1 | One-cycle abort request pulse |
| seq_proto | output | 8 | Stored protocol byte |
| seq_slave | output | 8 | Stored slave address byte |
| seq_cmd | output | 8 | Stored command byte |
| seq_count | output | 8 | Stored byte count |
| seq_buf_ridx | input | 5 | Sequencer buffer read index |
| seq_buf_rdata | output | 8 | Buffer byte at `seq_buf_ridx` |
| seq_buf_we | input | 1 | Sequencer buffer write enable |
| seq_buf_widx | input | 5 | Sequencer buffer write index |
| seq_buf_wdata | input | 8 | Sequencer buffer write data |
| seq_cnt_we | input | 1 | Sequencer count write enable |
| seq_cnt_wdata | input | 8 | Received byte count |
| seq_done | input | 1 | Transaction finished pulse |
| seq_err | input | 5 | Error code accompanying `seq_done` |
| seq_alarm | input | 1 | Alarm flag accompanying `seq_done` |
| seq_abort_ack | input | 1 | Abort completed pulse |

## Verification
Two pairs of functions can land in the same clock. In the first, a host start write coincides with the sequencer's done pulse. In the second, the sequencer's abort acknowledge coincides with a host write that clears the abort flag. A third collision arises when a host write and a sequencer write target the same buffer byte. The bench drives each pair on one edge and judges the outcome from the outputs that follow. A coincident start must produce no pulse and must give a 0x1F code. A coincident clear must leave the abort flag set. A coincident buffer write must leave the sequencer's byte.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int OFS_PROTO = 'h00;
  localparam int OFS_STS   = 'h01;
  localparam int OFS_SLAVE = 'h02;
  localparam int OFS_CMD   = 'h03;
  localparam int BUF_BASE  = 'h04;
  localparam int OFS_ABST  = 'h3C;
  localparam int OFS_CTRL  = 'h3E;

  localparam logic [7:0] CTRL_ABORT_BIT = 8'h20;
  localparam logic [4:0] CODE_COLLIDE   = 5'h1F;
  localparam logic [4:0] CODE_ABORTED   = 5'h1E;

  // Packs the status byte: done, alarm, reserved zero, error code.
  function automatic logic [7:0] status_byte(input logic done, input logic alarm,
                                             input logic [4:0] code);
    return {done, alarm, 1'b0, code};
  endfunction

  // A sequencer error wins over a recorded start collision.
  function automatic logic [4:0] pick_code(input logic [4:0] seq_code, input logic collided);
    if (seq_code != 5'd0) return seq_code;
    return collided ? CODE_COLLIDE : 5'd0;
  endfunction
endpackage

// File: rtl/smbh_databuf.sv
module smbh_databuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [IDXW-1:0] host_idx,
  input  logic [DW-1:0]   host_wdata,
  input  logic            seq_we,
  input  logic [IDXW-1:0] seq_idx,
  input  logic [DW-1:0]   seq_wdata,
  input  logic [IDXW-1:0] rd_idx_a,
  output logic [DW-1:0]   rd_a,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [DW-1:0]   rd_b
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic seq_hit, host_hit;
    assign seq_hit  = seq_we  && (seq_idx  == IDXW'(g));
    assign host_hit = host_we && (host_idx == IDXW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)        mem[g] <= '0;
      else if (seq_hit)  mem[g] <= seq_wdata;
      else if (host_hit) mem[g] <= host_wdata;
    end
  end

  assign rd_a = mem[rd_idx_a];
  assign rd_b = mem[rd_idx_b];
endmodule

// File: rtl/smbh_txn_ctrl.sv
module smbh_txn_ctrl
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       sts_w1c,
  input  logic       abst_w1c,
  input  logic       abort_req,
  input  logic [7:0] wdata,
  input  logic       seq_done,
  input  logic [4:0] seq_err,
  input  logic       seq_alarm,
  input  logic       seq_abort_ack,
  output logic       busy,
  output logic       start_acc,
  output logic       done_evt,
  output logic       ack_evt,
  output logic       seq_start,
  output logic       seq_abort,
  output logic [7:0] status_q,
  output logic       abort_flag
);
  logic collided;
  logic abort_acc;

  assign start_acc = start_req && !busy;
  assign abort_acc = abort_req && busy;
  assign ack_evt   = seq_abort_ack && busy;
  assign done_evt  = seq_done && busy && !seq_abort_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      collided  <= 1'b0;
      status_q  <= '0;
      seq_start <= 1'b0;
      seq_abort <= 1'b0;
    end else begin
      seq_start <= start_acc;
      seq_abort <= abort_acc;
      if (ack_evt) begin
        busy     <= 1'b0;
        collided <= 1'b0;
        status_q <= status_byte(1'b0, 1'b0, CODE_ABORTED);
      end else if (done_evt) begin
        busy     <= 1'b0;
        collided <= 1'b0;
        status_q <= status_byte(1'b1, seq_alarm, pick_code(seq_err, collided || start_req));
      end else if (busy) begin
        if (start_req) collided <= 1'b1;
      end else if (start_req) begin
        busy     <= 1'b1;
        collided <= 1'b0;
        status_q <= '0;
      end else if (sts_w1c) begin
        status_q <= status_q & ~wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     abort_flag <= 1'b0;
    else if (ack_evt)               abort_flag <= 1'b1;
    else if (abst_w1c && wdata[0])  abort_flag <= 1'b0;
  end
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbh_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int OFS_W     = 6,
  parameter int DW        = 8,
  localparam int IDXW     = $clog2(BUF_BYTES),
  localparam int OFS_CNT  = BUF_BASE + BUF_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            seq_start,
  output logic            seq_abort,
  output logic [DW-1:0]   seq_proto,
  output logic [DW-1:0]   seq_slave,
  output logic [DW-1:0]   seq_cmd,
  output logic [DW-1:0]   seq_count,
  input  logic [IDXW-1:0] seq_buf_ridx,
  output logic [DW-1:0]   seq_buf_rdata,
  input  logic            seq_buf_we,
  input  logic [IDXW-1:0] seq_buf_widx,
  input  logic [DW-1:0]   seq_buf_wdata,
  input  logic            seq_cnt_we,
  input  logic [DW-1:0]   seq_cnt_wdata,
  input  logic            seq_done,
  input  logic [4:0]      seq_err,
  input  logic            seq_alarm,
  input  logic            seq_abort_ack
);
  logic           busy, start_acc, done_evt, ack_evt, abort_flag;
  logic [7:0]     status_q;
  logic [DW-1:0]  proto_q, slave_q, cmd_q, cnt_q, ctrl_q;
  logic           hit_proto, hit_sts, hit_slave, hit_cmd, hit_cnt, hit_abst, hit_ctrl, hit_buf;
  logic [OFS_W-1:0] rel_ofs;
  logic [IDXW-1:0]  host_idx;
  logic [DW-1:0]    host_buf_rd;
  logic           start_req, cfg_wr_ok;

  assign hit_proto = reg_addr == OFS_W'(OFS_PROTO);
  assign hit_sts   = reg_addr == OFS_W'(OFS_STS);
  assign hit_slave = reg_addr == OFS_W'(OFS_SLAVE);
  assign hit_cmd   = reg_addr == OFS_W'(OFS_CMD);
  assign hit_cnt   = reg_addr == OFS_W'(OFS_CNT);
  assign hit_abst  = reg_addr == OFS_W'(OFS_ABST);
  assign hit_ctrl  = reg_addr == OFS_W'(OFS_CTRL);
  assign hit_buf   = (reg_addr >= OFS_W'(BUF_BASE)) && (reg_addr < OFS_W'(OFS_CNT));
  assign rel_ofs   = reg_addr - OFS_W'(BUF_BASE);
  assign host_idx  = rel_ofs[IDXW-1:0];

  assign start_req = reg_wr && hit_proto;
  assign cfg_wr_ok = reg_wr && !busy;

  smbh_txn_ctrl u_txn (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req),
    .sts_w1c(reg_wr && hit_sts),
    .abst_w1c(reg_wr && hit_abst),
    .abort_req(reg_wr && hit_ctrl && (reg_wdata[7:0] & CTRL_ABORT_BIT) != 8'h00),
    .wdata(reg_wdata[7:0]),
    .seq_done(seq_done), .seq_err(seq_err), .seq_alarm(seq_alarm),
    .seq_abort_ack(seq_abort_ack),
    .busy(busy), .start_acc(start_acc), .done_evt(done_evt), .ack_evt(ack_evt),
    .seq_start(seq_start), .seq_abort(seq_abort),
    .status_q(status_q), .abort_flag(abort_flag)
  );

  smbh_databuf #(.DEPTH(BUF_BYTES), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .host_we(cfg_wr_ok && hit_buf), .host_idx(host_idx), .host_wdata(reg_wdata),
    .seq_we(seq_buf_we), .seq_idx(seq_buf_widx), .seq_wdata(seq_buf_wdata),
    .rd_idx_a(host_idx), .rd_a(host_buf_rd),
    .rd_idx_b(seq_buf_ridx), .rd_b(seq_buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proto_q <= '0;
      slave_q <= '0;
      cmd_q   <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      if (start_acc)                proto_q <= reg_wdata;
      if (cfg_wr_ok && hit_slave)   slave_q <= reg_wdata;
      if (cfg_wr_ok && hit_cmd)     cmd_q   <= reg_wdata;
      if (seq_cnt_we)               cnt_q   <= seq_cnt_wdata;
      else if (cfg_wr_ok && hit_cnt) cnt_q  <= reg_wdata;
      if (reg_wr && hit_ctrl)       ctrl_q  <= reg_wdata & ~DW'(CTRL_ABORT_BIT);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_proto)      reg_rdata = proto_q;
    else if (hit_sts)   reg_rdata = busy ? '0 : DW'(status_q);
    else if (hit_slave) reg_rdata = slave_q;
    else if (hit_cmd)   reg_rdata = cmd_q;
    else if (hit_buf)   reg_rdata = host_buf_rd;
    else if (hit_cnt)   reg_rdata = cnt_q;
    else if (hit_abst)  reg_rdata = DW'(abort_flag);
    else if (hit_ctrl)  reg_rdata = ctrl_q;
  end

  assign seq_proto = proto_q;
  assign seq_slave = slave_q;
  assign seq_cmd   = cmd_q;
  assign seq_count = cnt_q;
endmodule

// File: rtl/smbh_host_regs_chk.sv
module smbh_host_regs_chk #(
  parameter int OFS_W = 6,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             start_req,
  input logic             start_acc,
  input logic             seq_start,
  input logic             seq_abort,
  input logic             done_evt,
  input logic             ack_evt,
  input logic             abort_flag,
  input logic [7:0]       status_q,
  input logic [OFS_W-1:0] reg_addr,
  input logic [DW-1:0]    reg_rdata
);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (seq_start && busy));
  // R3
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !$past(busy));
  // R3
  busy_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_addr == OFS_W'(smbh_pkg::OFS_STS)) |-> (reg_rdata == '0));
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> !seq_start);
  // R4
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && status_q[7]));
  // R9
  abort_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> $past(busy));
  // R10
  abort_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> (abort_flag && !busy));
  // R9
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_start, seq_abort}));
endmodule

bind smbus_host_regs smbh_host_regs_chk #(.OFS_W(OFS_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_req(start_req),
  .start_acc(start_acc), .seq_start(seq_start), .seq_abort(seq_abort),
  .done_evt(done_evt), .ack_evt(ack_evt), .abort_flag(abort_flag),
  .status_q(status_q), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/sim_smbus_host_regs.sv
`timescale 1ns/1ps
module sim_smbus_host_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic seq_start, seq_abort;
  logic [7:0] seq_proto, seq_slave, seq_cmd, seq_count, seq_buf_rdata;
  logic [4:0] seq_buf_ridx = '0;
  logic seq_buf_we = 1'b0;
  logic [4:0] seq_buf_widx = '0;
  logic [7:0] seq_buf_wdata = '0;
  logic seq_cnt_we = 1'b0;
  logic [7:0] seq_cnt_wdata = '0;
  logic seq_done = 1'b0;
  logic [4:0] seq_err = '0;
  logic seq_alarm = 1'b0;
  logic seq_abort_ack = 1'b0;

  int vecs = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  smbus_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seq_start(seq_start), .seq_abort(seq_abort), .seq_proto(seq_proto),
    .seq_slave(seq_slave), .seq_cmd(seq_cmd), .seq_count(seq_count),
    .seq_buf_ridx(seq_buf_ridx), .seq_buf_rdata(seq_buf_rdata),
    .seq_buf_we(seq_buf_we), .seq_buf_widx(seq_buf_widx), .seq_buf_wdata(seq_buf_wdata),
    .seq_cnt_we(seq_cnt_we), .seq_cnt_wdata(seq_cnt_wdata),
    .seq_done(seq_done), .seq_err(seq_err), .seq_alarm(seq_alarm),
    .seq_abort_ack(seq_abort_ack)
  );

  function automatic logic [7:0] pat_host(input int i);
    return 8'((i * 37 + 5) & 'hFF);
  endfunction
  function automatic logic [7:0] pat_seq(input int i);
    return 8'(((i * 91 + 17) ^ 'h3C) & 'hFF);
  endfunction
  function automatic logic [7:0] exp_done(input logic al, input logic [4:0] code);
    return 8'h80 + (al ? 8'h40 : 8'h00) + {3'b000, code};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_txn(input logic [4:0] e, input logic al);
    seq_done = 1'b1; seq_err = e; seq_alarm = al;
    @(posedge clk);
    @(negedge clk);
    seq_done = 1'b0; seq_err = '0; seq_alarm = 1'b0;
  endtask

  task automatic ack_abort();
    seq_abort_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    seq_abort_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      vecs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every offset reads zero, no pulses
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), d);
      chk("R1 reset read", d, 8'h00);
    end
    chk("R1 start idle", {7'd0, seq_start}, 8'h00);
    chk("R1 abort idle", {7'd0, seq_abort}, 8'h00);

    // R2: load and read back
    wr(6'h02, 8'hA6);
    wr(6'h03, 8'h5C);
    wr(6'h24, 8'h20);
    for (int i = 0; i < 32; i++) wr(6'(4 + i), pat_host(i));
    rd(6'h02, d); chk("R2 slave", d, 8'hA6);
    rd(6'h03, d); chk("R2 cmd", d, 8'h5C);
    rd(6'h24, d); chk("R2 count", d, 8'h20);
    chk("R2 seq_slave", seq_slave, 8'hA6);
    chk("R2 seq_cmd", seq_cmd, 8'h5C);
    chk("R2 seq_count", seq_count, 8'h20);
    for (int i = 0; i < 32; i++) begin
      rd(6'(4 + i), d);
      chk("R2 buf host", d, pat_host(i));
      seq_buf_ridx = 5'(i);
      #1;
      chk("R2 buf seq", seq_buf_rdata, pat_host(i));
    end
    for (int a = 'h25; a < 64; a++) begin
      if (a != 'h3C && a != 'h3E) begin
        rd(6'(a), d);
        chk("R2 unmapped", d, 8'h00);
      end
    end

    // R3: start from idle
    wr(6'h00, 8'h88);
    chk("R3 pulse high", {7'd0, seq_start}, 8'h01);
    chk("R3 seq_proto", seq_proto, 8'h88);
    rd(6'h01, d); chk("R3 status busy", d, 8'h00);
    @(negedge clk);
    chk("R3 pulse width", {7'd0, seq_start}, 8'h00);
    rd(6'h00, d); chk("R3 proto readback", d, 8'h88);

    // R6: writes while busy ignored
    wr(6'h02, 8'h11);
    wr(6'h07, 8'h22);
    wr(6'h24, 8'h33);
    rd(6'h02, d); chk("R6 slave kept", d, 8'hA6);
    rd(6'h07, d); chk("R6 buf kept", d, pat_host(3));
    rd(6'h24, d); chk("R6 count kept", d, 8'h20);

    // R5: start while busy
    wr(6'h00, 8'h44);
    chk("R5 no pulse", {7'd0, seq_start}, 8'h00);
    rd(6'h00, d); chk("R5 proto kept", d, 8'h88);
    rd(6'h01, d); chk("R3 still busy", d, 8'h00);
    finish_txn(5'd0, 1'b0);
    rd(6'h01, d); chk("R5 collide code", d, exp_done(1'b0, 5'h1F));

    // R7: write-one-to-clear
    wr(6'h01, 8'h0F);
    rd(6'h01, d); chk("R7 partial clear", d, 8'h90);
    wr(6'h01, 8'hFF);
    rd(6'h01, d); chk("R7 full clear", d, 8'h00);

    // R4 sweep over every error code, alarm alternating
    for (int e = 0; e < 32; e++) begin
      wr(6'h00, 8'h06);
      chk("R3 sweep pulse", {7'd0, seq_start}, 8'h01);
      rd(6'h01, d); chk("R7 start clears", d, 8'h00);
      finish_txn(5'(e), e[0]);
      rd(6'h01, d); chk("R4 status", d, exp_done(e[0], 5'(e)));
    end

    // R5: sequencer error wins over collision
    wr(6'h00, 8'h06);
    wr(6'h00, 8'h07);
    finish_txn(5'd3, 1'b0);
    rd(6'h01, d); chk("R5 seq err wins", d, exp_done(1'b0, 5'd3));

    // R5: start in same cycle as done
    wr(6'h00, 8'h06);
    reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 8'h66;
    seq_done = 1'b1; seq_err = 5'd0;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; seq_done = 1'b0;
    chk("R5 coincide no pulse", {7'd0, seq_start}, 8'h00);
    rd(6'h01, d); chk("R5 coincide code", d, exp_done(1'b0, 5'h1F));
    rd(6'h00, d); chk("R5 coincide proto", d, 8'h06);

    // R8: sequencer fills buffer and count
    wr(6'h00, 8'h0B);
    for (int i = 0; i < 32; i++) begin
      seq_buf_we = 1'b1; seq_buf_widx = 5'(i); seq_buf_wdata = pat_seq(i);
      @(posedge clk);
      @(negedge clk);
    end
    seq_buf_we = 1'b0;
    seq_cnt_we = 1'b1; seq_cnt_wdata = 8'h07;
    @(posedge clk);
    @(negedge clk);
    seq_cnt_we = 1'b0;
    finish_txn(5'd0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      rd(6'(4 + i), d);
      chk("R8 buf overwrite", d, pat_seq(i));
    end
    rd(6'h24, d); chk("R8 count", d, 8'h07);
    reg_wr = 1'b1; reg_addr = 6'h09; reg_wdata = 8'hAA;
    seq_buf_we = 1'b1; seq_buf_widx = 5'd5; seq_buf_wdata = 8'h55;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; seq_buf_we = 1'b0;
    rd(6'h09, d); chk("R8 collision", d, 8'h55);

    // R9: control byte
    wr(6'h3E, 8'h20);
    chk("R9 idle no abort", {7'd0, seq_abort}, 8'h00);
    rd(6'h3E, d); chk("R9 bit5 reads 0", d, 8'h00);
    wr(6'h3E, 8'hE1);
    rd(6'h3E, d); chk("R9 other bits", d, 8'hC1);
    rd(6'h3C, d); chk("R10 no flag idle", d, 8'h00);
    wr(6'h00, 8'h0A);
    wr(6'h3E, 8'h20);
    chk("R9 abort pulse", {7'd0, seq_abort}, 8'h01);
    @(negedge clk);
    chk("R9 abort width", {7'd0, seq_abort}, 8'h00);

    // R10: acknowledge and flag handling
    ack_abort();
    rd(6'h01, d); chk("R10 status code", d, 8'h1E);
    rd(6'h3C, d); chk("R10 flag set", d, 8'h01);
    wr(6'h3C, 8'h00);
    rd(6'h3C, d); chk("R10 write0 keeps", d, 8'h01);
    wr(6'h3C, 8'h01);
    rd(6'h3C, d); chk("R10 w1c clears", d, 8'h00);
    wr(6'h00, 8'h0A);
    chk("R10 idle after abort", {7'd0, seq_start}, 8'h01);
    reg_wr = 1'b1; reg_addr = 6'h3C; reg_wdata = 8'h01;
    seq_abort_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; seq_abort_ack = 1'b0;
    rd(6'h3C, d); chk("R10 set beats clear", d, 8'h01);
    rd(6'h01, d); chk("R10 status after ack", d, 8'h1E);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule